// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address for each beat of one SDRAM read or write burst. A controller pulses `start` together with a 9-bit starting column, a burst length code and an ordering choice. From the next clock on, the block presents one column per cycle on `col_out`. It qualifies each column with `col_valid` and marks the final beat of a fixed-length burst with `col_last`.

Sequential ordering counts upward in the low bits of the column and wraps inside an aligned block of the burst length. Interleaved ordering instead XORs the beat index into those low bits. Full-page bursts step through all 512 columns, wrapping from 511 to 0, and keep running until the controller cuts them off.

On any cycle, `stop` ends the running burst. Also on any cycle, a new `start` throws the running burst away and begins the new one. A start with a setting that cannot be honoured is refused and reported on `mode_err`.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After reset, and until the first accepted start, `col_valid`, `col_last` and `mode_err` are 0.
- R2: `len_code` selects the burst length: 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, 7 selects full page, and 4 to 6 are reserved. `interleave`=1 selects interleaved order. An accepted start sampled at one clock edge makes `col_valid`=1 with `col_out` equal to the start column after that edge.
- R3: In sequential order with burst length N, beat k keeps the column bits above the low log2(N) bits and sets the low bits to (start + k) mod N.
- R4: In interleaved order with burst length N, beat k equals the start column XOR k. Only the low log2(N) bits change.
- R5: `col_last` is 1 exactly on beat N-1 of a fixed-length burst. Unless a new start arrives, `col_valid` is 0 on the cycle after that beat. A one-beat burst shows a single beat with `col_last`=1.
- R6: A full-page burst advances by one column per cycle and wraps from 511 to 0. It never asserts `col_last` and runs until it is stopped or replaced.
- R7: When `stop`=1 without `start`, the beat shown in that cycle is the final one, and `col_valid` is 0 from the next cycle.
- R8: A start during a running burst replaces it: the next cycle shows beat 0 of the new burst. When `start` and `stop` arrive together, the start wins.
- R9: A start with `interleave`=1 and full page, or with a reserved length code, is refused. `mode_err` is 1 for the one following cycle, and no new burst begins. A running burst is unaffected by the refused start itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst (replaces any running one) |
| start_col | input | 9 | First column of the burst |
| len_code | input | 3 | Burst length selection |
| interleave | input | 1 | 1: interleaved order, 0: sequential order |
| stop | input | 1 | End the running burst after the current beat |
| col_out | output | 9 | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the last of a fixed-length burst |
| mode_err | output | 1 | One-cycle flag for a refused start |

## Verification
The bench starts bursts whose start columns sit near the end of their aligned block and near column 511. A design that carried the sequential increment into the upper bits, or failed to wrap the full page at 511, would then emit wrong columns. Interleaved bursts with odd start columns expose a design that added instead of XORing. Stops and restarts land in the middle of bursts, including a start and a stop in the same cycle, where a design with the wrong priority would go idle. Refused starts arrive during a running burst, so a design that aborted or reloaded on them shows a broken column sequence.

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen #(
  parameter int COL_W = 9,
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] FULL_CODE = 3'd7,
  parameter logic [CODE_W-1:0] MAX_POW_CODE = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              interleave,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              col_last,
  output logic              mode_err
);

  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic             legal;
  logic [COL_W-1:0] req_mask;
  logic             active_q, full_q, il_q, err_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;

  always_comb begin
    legal    = 1'b0;
    req_mask = '0;
    if (len_code == FULL_CODE) begin
      req_mask = ALL_ONES;
      legal    = !interleave;
    end else if (len_code <= MAX_POW_CODE) begin
      req_mask = COL_W'((32'd1 << len_code) - 32'd1);
      legal    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      il_q     <= 1'b0;
      err_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else begin
      err_q <= start && !legal;
      if (start && legal) begin
        active_q <= 1'b1;
        base_q   <= start_col;
        cnt_q    <= '0;
        mask_q   <= req_mask;
        full_q   <= (len_code == FULL_CODE);
        il_q     <= interleave;
      end else if (stop) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (col_last) active_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign col_valid = active_q;
  assign col_last  = active_q && !full_q && (cnt_q == mask_q);
  assign mode_err  = err_q;
  assign col_out   = il_q ? (base_q ^ cnt_q)
                          : ((base_q & ~mask_q) | ((base_q + cnt_q) & mask_q));

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && legal) |=> (col_valid && col_out == $past(start_col))); // R2

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid); // R5

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full_q && !start && !stop) |=>
      (col_valid && !col_last && col_out == COL_W'($past(col_out) + 1'b1))); // R6

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid); // R7

  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !legal) |=> mode_err); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(start)); // R9

endmodule

// File: tb/sdram_col_burst_gen_test.sv
module sdram_col_burst_gen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0;
  logic       stop = 1'b0;
  logic [8:0] col_out;
  logic       col_valid, col_last, mode_err;

  sdram_col_burst_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
    .mode_err(mode_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       valid;
    logic [8:0] col;
    logic       last;
    logic       err;
    string      req;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int fails = 0;

  // expected-burst state derived from the requirements
  logic       m_active = 1'b0;
  logic [8:0] m_base = '0;
  int         m_n = 0;       // 0 = full page
  logic       m_il = 1'b0;
  int         m_k = 0;

  function automatic logic [8:0] beat_col(logic [8:0] b, int k, int n, logic il);
    logic [8:0] msk;
    if (n == 0) return 9'((int'(b) + k) % 512);
    msk = 9'(n - 1);
    if (il) return b ^ 9'(k);
    return (b & ~msk) | (9'(int'(b) + k) & msk);
  endfunction

  task automatic cyc(input logic st, input logic [8:0] col, input logic [2:0] code,
                     input logic il, input logic stp, input string req);
    logic ok;
    exp_t e;
    ok = (code <= 3'd3) || (code == 3'd7 && !il);
    start = st; start_col = col; len_code = code; interleave = il; stop = stp;
    e.err = st && !ok;
    if (st && ok) begin
      m_active = 1'b1; m_base = col; m_n = (code == 3'd7) ? 0 : (1 << code);
      m_il = il; m_k = 0;
    end else if (stp) begin
      m_active = 1'b0;
    end else if (m_active) begin
      if (m_n != 0 && m_k == m_n - 1) m_active = 1'b0;
      else m_k = m_k + 1;
    end
    e.valid = m_active;
    e.col   = beat_col(m_base, m_k, m_n, m_il);
    e.last  = m_active && m_n != 0 && m_k == m_n - 1;
    e.req   = req;
    @(posedge clk);
    #2;
    start = 1'b0; stop = 1'b0;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 9'd0, 3'd0, 1'b0, 1'b0, req);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (col_valid !== e.valid || col_last !== e.last || mode_err !== e.err ||
          (e.valid && col_out !== e.col)) begin
        fails++;
        $display("FAIL %s: got v=%0b col=%0d last=%0b err=%0b, expected v=%0b col=%0d last=%0b err=%0b",
                 e.req, col_valid, col_out, col_last, mode_err, e.valid, e.col, e.last, e.err);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    vectors++;
    if (col_valid !== 1'b0 || col_last !== 1'b0 || mode_err !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%0b last=%0b err=%0b, expected 0 0 0", col_valid, col_last, mode_err);
    end
    rst_n = 1'b1;
    idle(2, "R1");
    // sequential BL4 near end of aligned block and of page
    cyc(1'b1, 9'd502, 3'd2, 1'b0, 1'b0, "R3");
    idle(5, "R3 R5");
    // sequential BL8 mid-block start
    cyc(1'b1, 9'd13, 3'd3, 1'b0, 1'b0, "R3");
    idle(9, "R3 R5");
    // sequential BL2 and BL1
    cyc(1'b1, 9'd301, 3'd1, 1'b0, 1'b0, "R3");
    idle(3, "R5");
    cyc(1'b1, 9'd77, 3'd0, 1'b0, 1'b0, "R5");
    idle(2, "R5");
    // interleave BL8 and BL4
    cyc(1'b1, 9'd5, 3'd3, 1'b1, 1'b0, "R4");
    idle(9, "R4 R5");
    cyc(1'b1, 9'd263, 3'd2, 1'b1, 1'b0, "R4");
    idle(5, "R4");
    // full page across 511 -> 0, then stopped
    cyc(1'b1, 9'd509, 3'd7, 1'b0, 1'b0, "R6");
    idle(7, "R6");
    cyc(1'b0, 9'd0, 3'd0, 1'b0, 1'b1, "R7");
    idle(2, "R7");
    // stop mid BL8
    cyc(1'b1, 9'd40, 3'd3, 1'b0, 1'b0, "R7");
    idle(2, "R7");
    cyc(1'b0, 9'd0, 3'd0, 1'b0, 1'b1, "R7");
    idle(2, "R7");
    // restart mid burst, and start together with stop
    cyc(1'b1, 9'd100, 3'd3, 1'b0, 1'b0, "R8");
    idle(2, "R8");
    cyc(1'b1, 9'd222, 3'd2, 1'b1, 1'b0, "R8");
    idle(1, "R8");
    cyc(1'b1, 9'd350, 3'd2, 1'b0, 1'b1, "R8");
    idle(5, "R8");
    // refused starts during a running burst
    cyc(1'b1, 9'd16, 3'd3, 1'b0, 1'b0, "R9");
    idle(1, "R9");
    cyc(1'b1, 9'd400, 3'd7, 1'b1, 1'b0, "R9");
    idle(1, "R9");
    cyc(1'b1, 9'd401, 3'd5, 1'b0, 1'b0, "R9");
    idle(6, "R9");
    cyc(1'b1, 9'd7, 3'd4, 1'b0, 1'b0, "R9");
    idle(3, "R9");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule